// File: doc/BRIEF.md
# Per-Flow Start-Time Tagger

This block is one stage of a line-rate packet pipeline. It stamps each packet with a start time for start-time fair queueing. A packet descriptor arrives, qualified by a valid strobe. It carries a source port, a destination port, a length and the current virtual time. Two cycles later the same descriptor leaves the block with two fields added: a flow index and a start tag. The block accepts one packet in every cycle. It applies no backpressure and keeps the input order.

The flow index comes from a 16-bit CRC of the port pair, scaled into the range of tracked flows. For each flow the block keeps the finish time of that flow's last packet. Every guarded packet performs one atomic read-modify-write on its own flow's entry. Packets that arrive back to back on the same flow see each other's updates, because a forwarding path carries the newest finish time. A separate guard input marks the packets whose match rule fired. Unguarded packets pass through unchanged and leave the state alone.

After reset a two-state controller runs. In state SWEEP it walks every flow entry and writes the minimum time into it, one entry per cycle. When it writes the last entry it takes the transition SWEEP→SERVE. In state SERVE the controller raises `ready` and hands the memory write port to the pipeline. The only way back to SWEEP is reset.

Top module: `sfq_start_tagger`

## Requirements
- R1: The flow index is computed in two steps. First, a CRC-16 is taken over the 32-bit word {sport, dport}: polynomial 0x1021, initial value 0xFFFF, most significant bit first, no reflection and no final XOR. The index is then (crc × NUM_FLOWS) >> 16.
- R2: After reset is released, `ready` is low for exactly NUM_FLOWS clock edges (state SWEEP). It then stays high until the next reset (state SERVE). After the sweep, every flow entry holds MIN_TIME (default 1).
- R3: A packet presented while `ready` is low is dropped. It produces no output and changes no flow entry.
- R4: A packet accepted at a clock edge appears on the outputs exactly two edges later. The port, length and virtual time fields are echoed unchanged, and the output order matches the input order.
- R5: Call the stored finish time of the packet's flow F. For a guarded packet with F > MIN_TIME and vtime < F, the start tag is F and the entry becomes F + len.
- R6: For every other guarded packet, the start tag is vtime and the entry becomes vtime + len.
- R7: All time arithmetic is 32-bit unsigned and wraps modulo 2^32.
- R8: Each guarded packet sees the entry exactly as left by every earlier guarded packet of the same flow, including a packet that arrived in the previous cycle.
- R9: For a packet with `in_guard` low, `out_hit` is low and the start tag equals its vtime. Its flow entry is left unchanged.
- R10: `out_flow` is always below NUM_FLOWS while `out_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; starts the sweep |
| ready | output | 1 | High in state SERVE; packets are accepted only then |
| in_valid | input | 1 | Input descriptor valid |
| in_guard | input | 1 | Match guard; high runs the finish-time transaction |
| in_sport | input | 16 | Source port |
| in_dport | input | 16 | Destination port |
| in_len | input | 16 | Packet length |
| in_vtime | input | 32 | Current virtual time |
| out_valid | output | 1 | Output descriptor valid |
| out_hit | output | 1 | Echo of the guard |
| out_sport | output | 16 | Echoed source port |
| out_dport | output | 16 | Echoed destination port |
| out_len | output | 16 | Echoed length |
| out_vtime | output | 32 | Echoed virtual time |
| out_flow | output | $clog2(NUM_FLOWS) | Flow index |
| out_start | output | 32 | Start tag |

## Verification
Two results are due at fixed times.
- `ready` must rise after exactly NUM_FLOWS edges from reset release. The bench samples it one cycle before and at that edge.
- Each accepted packet is due on the outputs at the second edge after the edge that accepted it.

The bench drives and samples on falling edges and keeps a cycle counter. Each expected record is stamped with its due cycle, that is, the drive cycle plus two. A record that arrives early or late, an output with no pending record, and a record that is still pending at the end are all reported. Start tags come from a bench model of the flow table that is updated in input order. This makes back-to-back packets of the same flow check the forwarding path.

// File: rtl/sfq_pkg.sv
package sfq_pkg;
    localparam int unsigned TIME_W = 32;
    localparam int unsigned LEN_W  = 16;
    localparam int unsigned PORT_W = 16;
    localparam int unsigned HASH_W = 16;
    localparam logic [HASH_W-1:0] HASH_POLY = 16'h1021;
    localparam logic [HASH_W-1:0] HASH_SEED = 16'hFFFF;

    typedef logic [TIME_W-1:0] vtime_t;
    typedef logic [LEN_W-1:0]  plen_t;
    typedef logic [PORT_W-1:0] port_t;

    typedef enum logic {
        ST_SWEEP = 1'b0,
        ST_SERVE = 1'b1
    } tag_state_e;
endpackage

// File: rtl/sfq_flow_hash.sv
module sfq_flow_hash
    import sfq_pkg::*;
#(
    parameter int unsigned NUM_FLOWS = 1000,
    localparam int unsigned FLOW_W = (NUM_FLOWS > 1) ? $clog2(NUM_FLOWS) : 1
) (
    input  port_t              sport,
    input  port_t              dport,
    output logic [FLOW_W-1:0]  flow
);
    logic [2*PORT_W-1:0] word;
    logic [HASH_W-1:0]   crc;
    logic                fb;

    assign word = {sport, dport};

    always_comb begin
        crc = HASH_SEED;
        fb  = 1'b0;
        for (int i = 2*PORT_W-1; i >= 0; i--) begin
            fb  = crc[HASH_W-1] ^ word[i];
            crc = {crc[HASH_W-2:0], 1'b0};
            if (fb) begin
                crc = crc ^ HASH_POLY;
            end
        end
    end

    // Multiply-high: maps 0..65535 onto 0..NUM_FLOWS-1 in one cycle.
    assign flow = FLOW_W'((32'(crc) * 32'(NUM_FLOWS)) >> HASH_W);
endmodule

// File: rtl/sfq_finish_mem.sv
module sfq_finish_mem
    import sfq_pkg::*;
#(
    parameter int unsigned DEPTH = 1000,
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  vtime_t        wdata,
    input  logic [AW-1:0] raddr,
    output vtime_t        rdata
);
    vtime_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we && (32'(waddr) < DEPTH)) begin
            mem[waddr] <= wdata;
        end
    end

    always_comb begin
        if (32'(raddr) < DEPTH) begin
            rdata = mem[raddr];
        end else begin
            rdata = '0;
        end
    end
endmodule

// File: rtl/sfq_tag_calc.sv
module sfq_tag_calc
    import sfq_pkg::*;
#(
    parameter int unsigned MIN_TIME = 1
) (
    input  logic   guard,
    input  vtime_t stored,
    input  vtime_t vtime,
    input  plen_t  len,
    output vtime_t start,
    output vtime_t finish
);
    logic backlog;

    always_comb begin
        backlog = (stored > TIME_W'(MIN_TIME)) && (vtime < stored);
        if (guard && backlog) begin
            start = stored;
        end else begin
            start = vtime;
        end
        finish = start + TIME_W'(len);
    end
endmodule

// File: rtl/sfq_start_tagger.sv
module sfq_start_tagger
    import sfq_pkg::*;
#(
    parameter int unsigned NUM_FLOWS = 1000,
    parameter int unsigned MIN_TIME  = 1,
    localparam int unsigned FLOW_W = (NUM_FLOWS > 1) ? $clog2(NUM_FLOWS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    output logic              ready,
    input  logic              in_valid,
    input  logic              in_guard,
    input  logic [15:0]       in_sport,
    input  logic [15:0]       in_dport,
    input  logic [15:0]       in_len,
    input  logic [31:0]       in_vtime,
    output logic              out_valid,
    output logic              out_hit,
    output logic [15:0]       out_sport,
    output logic [15:0]       out_dport,
    output logic [15:0]       out_len,
    output logic [31:0]       out_vtime,
    output logic [FLOW_W-1:0] out_flow,
    output logic [31:0]       out_start
);
    localparam logic [FLOW_W-1:0] LAST_IDX = FLOW_W'(NUM_FLOWS - 1);

    tag_state_e        state, nxt;
    logic [FLOW_W-1:0] sweep_cnt;

    logic              mem_we;
    logic [FLOW_W-1:0] mem_waddr;
    vtime_t            mem_wdata;
    vtime_t            mem_rdata;

    logic [FLOW_W-1:0] in_flow;

    // stage 1: hashed descriptor, state read
    logic              s1_valid, s1_guard;
    port_t             s1_sport, s1_dport;
    plen_t             s1_len;
    vtime_t            s1_vtime;
    logic [FLOW_W-1:0] s1_flow;

    // stage 2: result, state write-back
    logic              s2_valid, s2_guard;
    port_t             s2_sport, s2_dport;
    plen_t             s2_len;
    vtime_t            s2_vtime, s2_start, s2_fin;
    logic [FLOW_W-1:0] s2_flow;

    logic              fwd;
    vtime_t            stored, c_start, c_fin;

    // ---------------- controller: state register ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_SWEEP;
            sweep_cnt <= '0;
        end else begin
            state <= nxt;
            if (state == ST_SWEEP) begin
                sweep_cnt <= sweep_cnt + 1'b1;
            end
        end
    end

    // ---------------- controller: next state and outputs ----------------
    always_comb begin
        nxt       = state;
        ready     = 1'b0;
        mem_we    = 1'b0;
        mem_waddr = s2_flow;
        mem_wdata = s2_fin;
        unique case (state)
            ST_SWEEP: begin
                mem_we    = 1'b1;
                mem_waddr = sweep_cnt;
                mem_wdata = TIME_W'(MIN_TIME);
                if (sweep_cnt == LAST_IDX) begin
                    nxt = ST_SERVE;
                end
            end
            ST_SERVE: begin
                ready  = 1'b1;
                mem_we = s2_valid && s2_guard;
            end
            default: nxt = ST_SWEEP;
        endcase
    end

    // ---------------- hash ----------------
    sfq_flow_hash #(.NUM_FLOWS(NUM_FLOWS)) u_hash (
        .sport (in_sport),
        .dport (in_dport),
        .flow  (in_flow)
    );

    // ---------------- stage 1 register ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
        end else begin
            s1_valid <= in_valid && ready;
        end
        s1_guard <= in_guard;
        s1_sport <= in_sport;
        s1_dport <= in_dport;
        s1_len   <= in_len;
        s1_vtime <= in_vtime;
        s1_flow  <= in_flow;
    end

    // ---------------- state memory ----------------
    sfq_finish_mem #(.DEPTH(NUM_FLOWS)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (s1_flow),
        .rdata (mem_rdata)
    );

    // forward the finish time not yet written back
    assign fwd    = s2_valid && s2_guard && (s2_flow == s1_flow);
    assign stored = fwd ? s2_fin : mem_rdata;

    sfq_tag_calc #(.MIN_TIME(MIN_TIME)) u_calc (
        .guard  (s1_guard),
        .stored (stored),
        .vtime  (s1_vtime),
        .len    (s1_len),
        .start  (c_start),
        .finish (c_fin)
    );

    // ---------------- stage 2 register ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            s2_valid <= 1'b0;
        end else begin
            s2_valid <= s1_valid;
        end
        s2_guard <= s1_guard;
        s2_sport <= s1_sport;
        s2_dport <= s1_dport;
        s2_len   <= s1_len;
        s2_vtime <= s1_vtime;
        s2_flow  <= s1_flow;
        s2_start <= c_start;
        s2_fin   <= c_fin;
    end

    assign out_valid = s2_valid;
    assign out_hit   = s2_guard;
    assign out_sport = s2_sport;
    assign out_dport = s2_dport;
    assign out_len   = s2_len;
    assign out_vtime = s2_vtime;
    assign out_flow  = s2_flow;
    assign out_start = s2_start;
endmodule

// File: rtl/sfq_tagger_checker.sv
module sfq_tagger_checker #(
    parameter int unsigned NUM_FLOWS = 1000,
    parameter int unsigned MIN_TIME  = 1,
    localparam int unsigned FLOW_W = (NUM_FLOWS > 1) ? $clog2(NUM_FLOWS) : 1
) (
    input logic              clk,
    input logic              rst,
    input logic              ready,
    input logic              in_valid,
    input logic              out_valid,
    input logic              out_hit,
    input logic [31:0]       out_vtime,
    input logic [31:0]       out_start,
    input logic [FLOW_W-1:0] out_flow
);
    // R2: once in SERVE, ready never drops without reset
    a_r2_ready_holds: assert property (@(posedge clk) disable iff (rst)
        !$fell(ready));

    // R3: nothing leaves the block while the sweep runs
    a_r3_quiet_in_sweep: assert property (@(posedge clk) disable iff (rst)
        !ready |-> !out_valid);

    // R4: an accepted packet is on the outputs two edges later
    a_r4_latency: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ready) |=> ##1 out_valid);

    // R4: no output without an acceptance two edges earlier
    a_r4_no_spurious: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid && ready, 2));

    // R5: a tag other than vtime must be a backlogged finish time
    a_r5_tag_rule: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_hit && (out_start != out_vtime))
            |-> ((out_start > 32'(MIN_TIME)) && (out_vtime < out_start)));

    // R9: unguarded packets carry their own vtime as tag
    a_r9_unguarded: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_hit) |-> (out_start == out_vtime));

    // R10: flow index in range
    a_r10_flow_range: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (32'(out_flow) < NUM_FLOWS));
endmodule

bind sfq_start_tagger sfq_tagger_checker #(
    .NUM_FLOWS (NUM_FLOWS),
    .MIN_TIME  (MIN_TIME)
) u_checker (
    .clk       (clk),
    .rst       (rst),
    .ready     (ready),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_hit   (out_hit),
    .out_vtime (out_vtime),
    .out_start (out_start),
    .out_flow  (out_flow)
);

// File: tb/tb_sfq_start_tagger.sv
module tb_sfq_start_tagger;
    localparam int N    = 24;
    localparam int MINT = 1;
    localparam int FW   = $clog2(N);
    localparam int QD   = 1024;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ready;
    logic          in_valid = 1'b0, in_guard = 1'b0;
    logic [15:0]   in_sport = '0, in_dport = '0, in_len = '0;
    logic [31:0]   in_vtime = '0;
    logic          out_valid, out_hit;
    logic [15:0]   out_sport, out_dport, out_len;
    logic [31:0]   out_vtime, out_start;
    logic [FW-1:0] out_flow;

    always #5 clk = ~clk;

    sfq_start_tagger #(.NUM_FLOWS(N), .MIN_TIME(MINT)) dut (
        .clk(clk), .rst(rst), .ready(ready),
        .in_valid(in_valid), .in_guard(in_guard), .in_sport(in_sport),
        .in_dport(in_dport), .in_len(in_len), .in_vtime(in_vtime),
        .out_valid(out_valid), .out_hit(out_hit), .out_sport(out_sport),
        .out_dport(out_dport), .out_len(out_len), .out_vtime(out_vtime),
        .out_flow(out_flow), .out_start(out_start)
    );

    int nchk = 0, nerr = 0, cyc = 0;
    bit done = 1'b0;
    logic [31:0] model [N];

    int          e_cyc [QD];
    int          e_flow [QD];
    logic [31:0] e_start [QD];
    logic [31:0] e_vt [QD];
    logic [15:0] e_len [QD];
    logic [15:0] e_sp [QD];
    logic        e_hit [QD];
    string       e_tag [QD];
    int wr = 0, rd = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: got %0d (0x%0h) expected %0d (0x%0h)", req, got, got, exp, exp);
        end
    endtask

    // byte-wise CRC, independent formulation of R1
    function automatic logic [15:0] ref_crc(input logic [15:0] a, input logic [15:0] b);
        logic [31:0] w = {a, b};
        logic [15:0] c = 16'hFFFF;
        for (int k = 3; k >= 0; k--) begin
            c = c ^ {w[k*8 +: 8], 8'h00};
            for (int j = 0; j < 8; j++) begin
                c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
            end
        end
        return c;
    endfunction

    function automatic int ref_flow(input logic [15:0] a, input logic [15:0] b);
        return int'((32'(ref_crc(a, b)) * 32'(N)) >> 16);
    endfunction

    // drive one packet at a falling edge, record expectations, advance
    task automatic send(input bit g, input logic [15:0] sp, input logic [15:0] dp,
                        input logic [15:0] ln, input logic [31:0] vt, input string ctx);
        int f;
        logic [31:0] st, s;
        string t;
        f = ref_flow(sp, dp);
        if (g) begin
            st = model[f];
            if (st > 32'(MINT) && vt < st) begin
                s = st; t = "R5";
            end else begin
                s = vt; t = "R6";
            end
            model[f] = s + 32'(ln);
        end else begin
            s = vt; t = "R9";
        end
        e_cyc[wr % QD] = cyc + 2; e_flow[wr % QD] = f; e_start[wr % QD] = s;
        e_vt[wr % QD] = vt; e_len[wr % QD] = ln; e_sp[wr % QD] = sp;
        e_hit[wr % QD] = g; e_tag[wr % QD] = {t, " ", ctx};
        wr++;
        in_valid = 1'b1; in_guard = g; in_sport = sp; in_dport = dp;
        in_len = ln; in_vtime = vt;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // output monitor
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (rd == wr) begin
                chk(1'b0, "R3 R4 unexpected output", 32'(out_flow), 32'hFFFF_FFFF);
            end else begin
                chk(cyc == e_cyc[rd % QD], "R4 arrival cycle", 32'(cyc), 32'(e_cyc[rd % QD]));
                chk(32'(out_flow) == 32'(e_flow[rd % QD]), "R1 flow index", 32'(out_flow), 32'(e_flow[rd % QD]));
                chk(32'(out_flow) < 32'(N), "R10 flow range", 32'(out_flow), 32'(N - 1));
                chk(out_start == e_start[rd % QD], e_tag[rd % QD], out_start, e_start[rd % QD]);
                chk(out_hit == e_hit[rd % QD], "R9 hit echo", 32'(out_hit), 32'(e_hit[rd % QD]));
                chk(out_vtime == e_vt[rd % QD] && out_len == e_len[rd % QD] && out_sport == e_sp[rd % QD],
                    "R4 field echo", out_vtime, e_vt[rd % QD]);
                rd++;
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        chk(1'b0, "watchdog expired", 32'(cyc), 32'd0);
        finish_run();
    end

    initial begin
        for (int i = 0; i < N; i++) model[i] = 32'(MINT);
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(ready == 1'b0, "R2 ready low after reset", 32'(ready), 0);
        // R3: offer guarded packets during the whole sweep; all must drop
        in_valid = 1'b1; in_guard = 1'b1; in_sport = 16'd7; in_dport = 16'd9;
        in_len = 16'd500; in_vtime = 32'd3;
        repeat (N - 1) @(negedge clk);
        chk(ready == 1'b0, "R2 ready low one edge before sweep end", 32'(ready), 0);
        @(negedge clk);
        in_valid = 1'b0;
        chk(ready == 1'b1, "R2 ready high after NUM_FLOWS edges", 32'(ready), 1);
        idle(3);

        // R3: the dropped flow must still read as fresh (start = vtime)
        send(1, 16'd7, 16'd9, 16'd10, 32'd2, "R3 fresh after drops");
        // R6 at vtime 0 on a fresh flow, then R8 back-to-back same flow
        send(1, 16'd1, 16'd2, 16'd100, 32'd0, "fresh vt0");
        send(1, 16'd1, 16'd2, 16'd40, 32'd5, "R8 b2b");
        send(1, 16'd1, 16'd2, 16'd40, 32'd6, "R8 b2b");
        send(1, 16'd1, 16'd2, 16'd40, 32'd7, "R8 b2b");
        // one-cycle gap (via another flow) exercises the memory path
        send(1, 16'd3, 16'd4, 16'd8, 32'd1, "other flow");
        send(1, 16'd1, 16'd2, 16'd1, 32'd8, "R8 gap one");
        idle(2);
        // R9: unguarded with large vtime, then guarded must see old state
        send(0, 16'd1, 16'd2, 16'd999, 32'd5000, "R9 unguarded");
        send(1, 16'd1, 16'd2, 16'd1, 32'd9, "R9 state kept");
        idle(1);
        // R6 equality: vtime equal to stored finish
        send(1, 16'd5, 16'd6, 16'd20, 32'd50, "R6 seed");
        idle(2);
        send(1, 16'd5, 16'd6, 16'd20, 32'd70, "R6 vt equals stored");
        // R7: wrap past 2^32
        send(1, 16'd11, 16'd12, 16'h0020, 32'hFFFF_FFF0, "R7 wrap seed");
        send(1, 16'd11, 16'd12, 16'h0005, 32'hFFFF_FFF5, "R7 after wrap");
        send(1, 16'd11, 16'd12, 16'h0005, 32'd3, "R7 small vt after wrap");
        idle(3);
        // near-exhaustive sweep of port pairs, back-to-back, many collisions
        for (int i = 0; i < 256; i++) begin
            send(((i % 7) != 3), 16'(i >> 4), 16'(i & 15), 16'(1 + (i % 64) * 3),
                 32'((i * 37) % 500), "sweep");
            if ((i % 50) == 49) idle(1);
        end
        idle(4);
        chk(rd == wr, "R4 all packets delivered", 32'(rd), 32'(wr));
        finish_run();
    end
endmodule